// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks a singly linked chain of 32-bit extended capability headers kept in a 4 KB configuration space. It has two jobs. A find request looks for a capability ID and returns where that header sits and which header points at it. An append request links a new header into the chain. Each header holds an ID in its low sixteen bits, a four-bit version above that, and a twelve-bit byte offset of the next header in the top bits. A next offset of zero ends the chain. The chain always starts at byte offset 256.

A request is presented with `reqValid` while the engine is idle, and the engine accepts it on that clock edge. The engine then drives a single word-wide read/write port into the configuration memory, which returns read data one cycle after a read. Every pointer it follows is checked: the offset must be word aligned and must lie between 256 and the last two words of the space. A hop ceiling stops a chain that loops back on itself. The result comes back with a one-cycle `done` pulse. ID 0 is reserved, so a find for ID 0 never matches and instead reports the last header in the chain. Append uses this to locate the tail, and then changes only the tail's next field.

Top module: `capwalk_top`

## Requirements
- R1: A header word carries the ID in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. The engine writes headers in exactly this layout.
- R2: A find whose header at offset 256 is all zero finishes with found=0, err=0, resOffset=0 and resPrev=0.
- R3: A find stops at the first header in chain order whose ID equals a nonzero requested ID. It reports found=1, resOffset equal to that header's offset, and resPrev equal to the offset of the header before it (0 when the match is at 256).
- R4: A find that reaches a zero next pointer without a match reports found=0, resOffset=0, and resPrev equal to the offset of the last header. A requested ID of 0 never matches.
- R5: A nonzero next pointer that has either of its low two bits set, is below 256, or is above 4088 ends the walk with err=1, found=0, resOffset=0, resPrev=0 and no memory write.
- R6: A walk follows at most MAX_HOPS next pointers. A walk that would need one more ends with err=1 and no write.
- R7: An append at offset 256 writes the new ID and version at 256 and keeps the next field that was already there. It reports resOffset=256 and resPrev=0.
- R8: An append at any other offset first walks to the tail. It rewrites the tail's next field with the new offset and leaves the tail's bits 19:0 unchanged. It then writes the new header with next=0, and reports resOffset equal to the new offset and resPrev equal to the tail offset.
- R9: An append whose offset breaks the pointer rule of R5, or that targets an offset other than 256 while the header at 256 is all zero, ends with err=1 and no memory write.
- R10: `busy` is high from the cycle after acceptance until `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R11: A request raised while busy is ignored. It produces no extra `done`, no memory write and no change to the results.
- R12: Read data is consumed the cycle after a read strobe (memEn=1, memWe=0). Every access addresses a word at byte offset 256 or above, and happens only while busy.
- R13: During reset, done, busy, found, err, resOffset, resPrev and memEn are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only when idle |
| reqOp | input | 1 | 0 = find, 1 = append |
| reqId | input | ID_W | Capability ID to find or to write |
| reqVer | input | VER_W | Version written by append |
| reqOffset | input | ADDR_W | Byte offset of the new header for append |
| busy | output | 1 | Engine is working on a request |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Find matched a header |
| err | output | 1 | Pointer, offset, empty-chain or hop-limit error |
| resOffset | output | ADDR_W | Matching or appended header offset |
| resPrev | output | ADDR_W | Predecessor or tail header offset |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write when memEn is high |
| memAddr | output | ADDR_W-2 | Word address into configuration memory |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read |

## Verification
The bench builds the engine with MAX_HOPS set to 4 and leaves the address, ID and version widths at their defaults. The small hop ceiling lets the bench reach the limit with short chains. A five-header chain needs exactly four hops and must succeed, while a six-header chain and a header that points at itself must both be stopped. The full 4 KB space stays in place, so both pointer bounds can be tested: a header at 4088 is legal and 4092 is rejected.

// File: rtl/capwalk_pkg.sv
package capwalk_pkg;

  // Result classes chosen by the control when a request finishes
  typedef enum logic [2:0] {
    RK_FOUND,
    RK_TAIL,
    RK_EMPTY,
    RK_ERR,
    RK_APPEND
  } resKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     startWalk;
    logic     stepNext;
    logic     keepHdr;
    logic     memRd;
    logic     wrTail;
    logic     wrNew;
    logic     finish;
    resKind_e kind;
  } ctlStrobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic opAppend;
    logic offOk;
    logic offAtBase;
    logic curAtBase;
    logic hdrZero;
    logic idHit;
    logic nextZero;
    logic nextOk;
  } dpStatus_t;

endpackage

// File: rtl/capwalk_ctrl.sv
module capwalk_ctrl
  import capwalk_pkg::*;
#(
  parameter int MAX_HOPS = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  dpStatus_t  st,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       done
);

  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_ISSUE,
    S_EVAL,
    S_WTAIL,
    S_WNEW
  } state_e;

  state_e           state, stateNxt;
  logic [HOP_W-1:0] hopCnt;
  logic             hopLimit;

  assign hopLimit = (hopCnt == HOP_W'(MAX_HOPS));
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.latchReq  = 1'b1;
          stb.startWalk = 1'b1;
          stateNxt      = S_START;
        end
      end
      S_START: begin
        if (st.opAppend && !st.offOk) begin
          stb.finish = 1'b1;
          stb.kind   = RK_ERR;
          stateNxt   = S_IDLE;
        end else begin
          stateNxt = S_ISSUE;
        end
      end
      S_ISSUE: begin
        stb.memRd = 1'b1;
        stateNxt  = S_EVAL;
      end
      S_EVAL: begin
        stb.keepHdr = 1'b1;
        if (st.opAppend && st.offAtBase) begin
          stateNxt = S_WNEW;
        end else if (st.curAtBase && st.hdrZero) begin
          stb.finish = 1'b1;
          stb.kind   = st.opAppend ? RK_ERR : RK_EMPTY;
          stateNxt   = S_IDLE;
        end else if (st.idHit) begin
          stb.finish = 1'b1;
          stb.kind   = RK_FOUND;
          stateNxt   = S_IDLE;
        end else if (st.nextZero) begin
          if (st.opAppend) begin
            stateNxt = S_WTAIL;
          end else begin
            stb.finish = 1'b1;
            stb.kind   = RK_TAIL;
            stateNxt   = S_IDLE;
          end
        end else if (!st.nextOk || hopLimit) begin
          stb.finish = 1'b1;
          stb.kind   = RK_ERR;
          stateNxt   = S_IDLE;
        end else begin
          stb.stepNext = 1'b1;
          stateNxt     = S_ISSUE;
        end
      end
      S_WTAIL: begin
        stb.wrTail = 1'b1;
        stateNxt   = S_WNEW;
      end
      S_WNEW: begin
        stb.wrNew  = 1'b1;
        stb.finish = 1'b1;
        stb.kind   = RK_APPEND;
        stateNxt   = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      hopCnt <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= stb.finish;
      if (stb.startWalk) begin
        hopCnt <= '0;
      end else if (stb.stepNext) begin
        hopCnt <= hopCnt + HOP_W'(1);
      end
    end
  end

endmodule

// File: rtl/capwalk_dp.sv
module capwalk_dp
  import capwalk_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ID_W     = 16,
  parameter int VER_W    = 4,
  parameter int BASE_OFF = 256
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     stb,
  input  logic                           reqOp,
  input  logic [ID_W-1:0]                reqId,
  input  logic [VER_W-1:0]               reqVer,
  input  logic [ADDR_W-1:0]              reqOffset,
  input  logic [ADDR_W+VER_W+ID_W-1:0]   memRdata,
  output dpStatus_t                      st,
  output logic                           memEn,
  output logic                           memWe,
  output logic [ADDR_W-3:0]              memAddr,
  output logic [ADDR_W+VER_W+ID_W-1:0]   memWdata,
  output logic                           found,
  output logic                           err,
  output logic [ADDR_W-1:0]              resOffset,
  output logic [ADDR_W-1:0]              resPrev
);

  localparam int HDR_W   = ADDR_W + VER_W + ID_W;
  localparam int LOW_W   = VER_W + ID_W;
  localparam int TOP_OFF = (1 << ADDR_W) - 8;

  logic              opAppendQ;
  logic [ID_W-1:0]   idQ;
  logic [VER_W-1:0]  verQ;
  logic [ADDR_W-1:0] offQ;
  logic [ADDR_W-1:0] curOff;
  logic [ADDR_W-1:0] prevOff;
  logic [HDR_W-1:0]  hdrQ;
  logic [ID_W-1:0]   rdId;
  logic [ADDR_W-1:0] rdNext;
  logic [ADDR_W-1:0] newNext;
  logic [ADDR_W-1:0] accOff;

  function automatic logic ptrLegal(input logic [ADDR_W-1:0] p);
    return (p[1:0] == 2'b00) && (p >= ADDR_W'(BASE_OFF)) &&
           (p <= ADDR_W'(TOP_OFF));
  endfunction

  assign rdId   = memRdata[ID_W-1:0];
  assign rdNext = memRdata[HDR_W-1 -: ADDR_W];

  always_comb begin
    st.opAppend  = opAppendQ;
    st.offOk     = ptrLegal(offQ);
    st.offAtBase = (offQ == ADDR_W'(BASE_OFF));
    st.curAtBase = (curOff == ADDR_W'(BASE_OFF));
    st.hdrZero   = (memRdata == '0);
    st.idHit     = !opAppendQ && (idQ != '0) && (rdId == idQ);
    st.nextZero  = (rdNext == '0);
    st.nextOk    = ptrLegal(rdNext);
  end

  // Memory port: reads and the tail rewrite use the walk cursor,
  // the new-header write uses the requested offset.
  assign newNext = st.offAtBase ? hdrQ[HDR_W-1 -: ADDR_W] : '0;
  assign accOff  = stb.wrNew ? offQ : curOff;
  assign memEn   = stb.memRd | stb.wrTail | stb.wrNew;
  assign memWe   = stb.wrTail | stb.wrNew;
  assign memAddr = accOff[ADDR_W-1:2];

  always_comb begin
    memWdata = '0;
    if (stb.wrTail) begin
      memWdata = {offQ, hdrQ[LOW_W-1:0]};
    end else if (stb.wrNew) begin
      memWdata = {newNext, verQ, idQ};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAppendQ <= 1'b0;
      idQ       <= '0;
      verQ      <= '0;
      offQ      <= '0;
      curOff    <= '0;
      prevOff   <= '0;
      hdrQ      <= '0;
    end else begin
      if (stb.latchReq) begin
        opAppendQ <= reqOp;
        idQ       <= reqId;
        verQ      <= reqVer;
        offQ      <= reqOffset;
      end
      if (stb.startWalk) begin
        curOff  <= ADDR_W'(BASE_OFF);
        prevOff <= '0;
      end else if (stb.stepNext) begin
        prevOff <= curOff;
        curOff  <= rdNext;
      end
      if (stb.keepHdr) begin
        hdrQ <= memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      found     <= 1'b0;
      err       <= 1'b0;
      resOffset <= '0;
      resPrev   <= '0;
    end else if (stb.finish) begin
      found <= (stb.kind == RK_FOUND);
      err   <= (stb.kind == RK_ERR);
      unique case (stb.kind)
        RK_FOUND: begin
          resOffset <= curOff;
          resPrev   <= prevOff;
        end
        RK_TAIL: begin
          resOffset <= '0;
          resPrev   <= curOff;
        end
        RK_APPEND: begin
          resOffset <= offQ;
          resPrev   <= st.offAtBase ? '0 : curOff;
        end
        default: begin
          resOffset <= '0;
          resPrev   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/capwalk_top.sv
module capwalk_top
  import capwalk_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int ID_W     = 16,
  parameter int VER_W    = 4,
  parameter int BASE_OFF = 256,
  parameter int MAX_HOPS = 1024
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  input  logic                         reqOp,
  input  logic [ID_W-1:0]              reqId,
  input  logic [VER_W-1:0]             reqVer,
  input  logic [ADDR_W-1:0]            reqOffset,
  output logic                         busy,
  output logic                         done,
  output logic                         found,
  output logic                         err,
  output logic [ADDR_W-1:0]            resOffset,
  output logic [ADDR_W-1:0]            resPrev,
  output logic                         memEn,
  output logic                         memWe,
  output logic [ADDR_W-3:0]            memAddr,
  output logic [ADDR_W+VER_W+ID_W-1:0] memWdata,
  input  logic [ADDR_W+VER_W+ID_W-1:0] memRdata
);

  ctlStrobe_t stb;
  dpStatus_t  st;

  capwalk_ctrl #(
    .MAX_HOPS(MAX_HOPS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .st      (st),
    .stb     (stb),
    .busy    (busy),
    .done    (done)
  );

  capwalk_dp #(
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .VER_W   (VER_W),
    .BASE_OFF(BASE_OFF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqOp    (reqOp),
    .reqId    (reqId),
    .reqVer   (reqVer),
    .reqOffset(reqOffset),
    .memRdata (memRdata),
    .st       (st),
    .memEn    (memEn),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .found    (found),
    .err      (err),
    .resOffset(resOffset),
    .resPrev  (resPrev)
  );

endmodule

// File: rtl/capwalk_chk.sv
module capwalk_chk #(
  parameter int ADDR_W   = 12,
  parameter int BASE_OFF = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic              err,
  input logic [ADDR_W-1:0] resOffset,
  input logic [ADDR_W-1:0] resPrev,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-3:0] memAddr
);

  localparam int WORD_W = ADDR_W - 2;

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy);

  p_hold_results_r11: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(resOffset) && $stable(resPrev) &&
               $stable(found) && $stable(err)));

  p_found_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (!err && (resOffset >= ADDR_W'(BASE_OFF))));

  p_err_clean_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (!found && (resOffset == '0) && (resPrev == '0)));

  p_mem_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (memAddr >= WORD_W'(BASE_OFF / 4)));

  p_mem_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> busy);

  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (busy && !done));

endmodule

bind capwalk_top capwalk_chk #(
  .ADDR_W  (ADDR_W),
  .BASE_OFF(BASE_OFF)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .busy     (busy),
  .done     (done),
  .found    (found),
  .err      (err),
  .resOffset(resOffset),
  .resPrev  (resPrev),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/capwalk_top_bench.sv
module capwalk_top_bench;

  localparam int ADDR_W   = 12;
  localparam int ID_W     = 16;
  localparam int VER_W    = 4;
  localparam int BASE_OFF = 256;
  localparam int MAX_HOPS = 4;
  localparam int HDR_W    = ADDR_W + VER_W + ID_W;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int WORDS    = 1 << WORD_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic              reqValid;
  logic              reqOp;
  logic [ID_W-1:0]   reqId;
  logic [VER_W-1:0]  reqVer;
  logic [ADDR_W-1:0] reqOffset;
  logic              busy, done, found, err;
  logic [ADDR_W-1:0] resOffset, resPrev;
  logic              memEn, memWe;
  logic [WORD_W-1:0] memAddr;
  logic [HDR_W-1:0]  memWdata;
  logic [HDR_W-1:0]  memRdata;

  capwalk_top #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .VER_W(VER_W),
    .BASE_OFF(BASE_OFF), .MAX_HOPS(MAX_HOPS)
  ) u_capwalk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqId(reqId), .reqVer(reqVer), .reqOffset(reqOffset),
    .busy(busy), .done(done), .found(found), .err(err),
    .resOffset(resOffset), .resPrev(resPrev),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Configuration memory model with a bench-side load port
  logic [HDR_W-1:0]  mem [WORDS];
  logic              tbWe, tbClr;
  logic [WORD_W-1:0] tbAddr;
  logic [HDR_W-1:0]  tbData;
  int                wrCnt = 0, doneCnt = 0, lowAcc = 0;

  always @(posedge clk) begin
    if (tbClr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (tbWe) begin
      mem[tbAddr] <= tbData;
    end else if (memEn && memWe) begin
      mem[memAddr] <= memWdata;
    end
    if (memEn && !memWe) memRdata <= mem[memAddr];
  end

  always @(posedge clk) begin
    if (rstN && memEn && memWe) wrCnt <= wrCnt + 1;
    if (rstN && done) doneCnt <= doneCnt + 1;
    if (rstN && memEn && (memAddr < WORD_W'(BASE_OFF / 4))) lowAcc <= lowAcc + 1;
  end

  int nChecks = 0;
  int nErr    = 0;
  logic              rFound, rErr;
  logic [ADDR_W-1:0] rOff, rPrev;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, what, act, exp);
  endtask

  function automatic logic [HDR_W-1:0] hdr(input logic [15:0] id,
                                           input logic [3:0] ver,
                                           input logic [11:0] nxt);
    return {nxt, ver, id};
  endfunction

  task automatic poke(input int off, input logic [HDR_W-1:0] val);
    @(negedge clk);
    tbAddr = off[ADDR_W-1:2];
    tbData = val;
    tbWe   = 1'b1;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic clearMem();
    @(negedge clk);
    tbClr = 1'b1;
    @(negedge clk);
    tbClr = 1'b0;
  endtask

  // spam: raise an append request at 256 while the engine is busy
  task automatic runOp(input logic op, input logic [15:0] id, input logic [3:0] ver,
                       input logic [11:0] off, input bit spam);
    int n = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqId = id; reqVer = ver; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    checkEq("R10", "busy after accept", busy, 1);
    if (spam) begin
      reqValid = 1'b1; reqOp = 1'b1; reqId = 16'h0077; reqVer = 4'h7;
      reqOffset = 12'h100;
      @(negedge clk);
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, "R10", "done seen", done, 1);
    rFound = found; rErr = err; rOff = resOffset; rPrev = resPrev;
    checkEq("R10", "busy low with done", busy, 0);
    @(negedge clk);
    checkEq("R10", "done one cycle", done, 0);
  endtask

  // Reference chain: 256(id1) -> 320(idB) -> 512(id10) -> 384(idB) -> end
  task automatic loadChain();
    clearMem();
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h140));
    poke(12'h140, hdr(16'h000B, 4'h2, 12'h200));
    poke(12'h200, hdr(16'h0010, 4'h1, 12'h180));
    poke(12'h180, hdr(16'h000B, 4'h3, 12'h000));
  endtask

  typedef struct packed {
    logic [15:0] id;
    logic        expFound;
    logic [11:0] expOff;
    logic [11:0] expPrev;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h0001, 1'b1, 12'h100, 12'h000},
    '{16'h000B, 1'b1, 12'h140, 12'h100},
    '{16'h0010, 1'b1, 12'h200, 12'h140},
    '{16'h0000, 1'b0, 12'h000, 12'h180},
    '{16'h00FF, 1'b0, 12'h000, 12'h180}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL R10 watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    int w0, d0;
    rstN = 1'b0; reqValid = 1'b0; reqOp = 1'b0; reqId = '0; reqVer = '0;
    reqOffset = '0; tbWe = 1'b0; tbClr = 1'b0; tbAddr = '0; tbData = '0;
    clearMem();
    repeat (3) @(negedge clk);
    // R13 reset state
    checkEq("R13", "done in reset", done, 0);
    checkEq("R13", "busy in reset", busy, 0);
    checkEq("R13", "found in reset", found, 0);
    checkEq("R13", "err in reset", err, 0);
    checkEq("R13", "resOffset in reset", resOffset, 0);
    checkEq("R13", "resPrev in reset", resPrev, 0);
    checkEq("R13", "memEn in reset", memEn, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 empty chain
    runOp(1'b0, 16'h0001, 4'h0, 12'h000, 1'b0);
    checkEq("R2", "empty found", rFound, 0);
    checkEq("R2", "empty err", rErr, 0);
    checkEq("R2", "empty prev", rPrev, 0);

    // R3/R4 vector table on the reference chain
    loadChain();
    foreach (VECS[k]) begin
      runOp(1'b0, VECS[k].id, 4'h0, 12'h000, 1'b0);
      checkEq(VECS[k].expFound ? "R3" : "R4", "find found", rFound, VECS[k].expFound);
      checkEq(VECS[k].expFound ? "R3" : "R4", "find offset", rOff, VECS[k].expOff);
      checkEq(VECS[k].expFound ? "R3" : "R4", "find prev", rPrev, VECS[k].expPrev);
      checkEq(VECS[k].expFound ? "R3" : "R4", "find err", rErr, 0);
    end

    // R11 request while busy ignored
    d0 = doneCnt; w0 = wrCnt;
    runOp(1'b0, 16'h0010, 4'h0, 12'h000, 1'b1);
    repeat (4) @(negedge clk);
    checkEq("R11", "result of first request", rOff, 12'h200);
    checkEq("R11", "single done", doneCnt - d0, 1);
    checkEq("R11", "no write", wrCnt - w0, 0);
    checkEq("R11", "base header intact", mem[64], hdr(16'h0001, 4'h1, 12'h140));

    // R8 append at tail, R1 layout of written headers
    runOp(1'b1, 16'h0044, 4'h5, 12'h600, 1'b0);
    checkEq("R8", "append offset", rOff, 12'h600);
    checkEq("R8", "append prev", rPrev, 12'h180);
    checkEq("R8", "append err", rErr, 0);
    checkEq("R8", "tail rewritten", mem[12'h180 >> 2], hdr(16'h000B, 4'h3, 12'h600));
    checkEq("R8", "new header", mem[12'h600 >> 2], hdr(16'h0044, 4'h5, 12'h000));
    checkEq("R1", "version field 19:16", (mem[12'h600 >> 2] >> 16) & 32'hF, 5);
    runOp(1'b0, 16'h0044, 4'h0, 12'h000, 1'b0);
    checkEq("R3", "find appended", rOff, 12'h600);
    checkEq("R3", "appended prev", rPrev, 12'h180);

    // R7 append at base keeps next pointer
    runOp(1'b1, 16'h0033, 4'h4, 12'h100, 1'b0);
    checkEq("R7", "base header", mem[64], hdr(16'h0033, 4'h4, 12'h140));
    checkEq("R7", "base offset", rOff, 12'h100);
    checkEq("R7", "base prev", rPrev, 0);
    clearMem();
    runOp(1'b1, 16'h0022, 4'h2, 12'h100, 1'b0);
    checkEq("R7", "base on empty", mem[64], hdr(16'h0022, 4'h2, 12'h000));

    // R9 bad append offsets and empty chain
    w0 = wrCnt;
    runOp(1'b1, 16'h0050, 4'h1, 12'h102, 1'b0);
    checkEq("R9", "unaligned offset err", rErr, 1);
    runOp(1'b1, 16'h0050, 4'h1, 12'h080, 1'b0);
    checkEq("R9", "low offset err", rErr, 1);
    clearMem();
    runOp(1'b1, 16'h0050, 4'h1, 12'h200, 1'b0);
    checkEq("R9", "empty chain append err", rErr, 1);
    checkEq("R9", "no write on error", wrCnt - w0, 0);
    checkEq("R9", "target untouched", mem[12'h200 >> 2], 0);

    // R5 pointer checks and upper bound
    w0 = wrCnt;
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h102));
    runOp(1'b0, 16'h0009, 4'h0, 12'h000, 1'b0);
    checkEq("R5", "unaligned pointer err", rErr, 1);
    checkEq("R5", "err offset", rOff, 0);
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h0FC));
    runOp(1'b0, 16'h0009, 4'h0, 12'h000, 1'b0);
    checkEq("R5", "low pointer err", rErr, 1);
    poke(12'h100, hdr(16'h0001, 4'h1, 12'hFFC));
    runOp(1'b0, 16'h0009, 4'h0, 12'h000, 1'b0);
    checkEq("R5", "high pointer err", rErr, 1);
    checkEq("R5", "no write", wrCnt - w0, 0);
    poke(12'h100, hdr(16'h0001, 4'h1, 12'hFF8));
    poke(12'hFF8, hdr(16'h0005, 4'h1, 12'h000));
    runOp(1'b0, 16'h0005, 4'h0, 12'h000, 1'b0);
    checkEq("R5", "pointer 4088 legal", rFound, 1);
    checkEq("R5", "found at 4088", rOff, 12'hFF8);

    // R6 hop ceiling (MAX_HOPS = 4)
    clearMem();
    for (int h = 0; h < 5; h++)
      poke(256 + 4 * h, hdr(16'(h + 1), 4'h1, (h == 4) ? 12'h000 : 12'(260 + 4 * h)));
    runOp(1'b0, 16'h0099, 4'h0, 12'h000, 1'b0);
    checkEq("R6", "four hops ok err", rErr, 0);
    checkEq("R6", "four hops tail", rPrev, 12'h110);
    poke(12'h110, hdr(16'h0005, 4'h1, 12'h114));
    poke(12'h114, hdr(16'h0006, 4'h1, 12'h000));
    runOp(1'b0, 16'h0099, 4'h0, 12'h000, 1'b0);
    checkEq("R6", "five hops err", rErr, 1);
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h100));
    runOp(1'b0, 16'h0099, 4'h0, 12'h000, 1'b0);
    checkEq("R6", "self loop err", rErr, 1);

    // R12 no access below the extended space
    checkEq("R12", "accesses below 256", lowAcc, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule